// File: doc/BRIEF.md
# Double-Buffered Pulse Parameter Register Bank

This block holds the timing parameters of a programmable pulse generator: five 10-bit values that the compare logic of the generator uses. Software reaches them through a byte-wide bus. Each value sits at two adjacent addresses. The low byte is at the even address and the high byte is at the odd address. Software writes the low byte first. That byte waits in a per-register holding latch. When the high byte arrives, the full 10-bit value goes into the buffer stage in one step. A half-written value therefore never appears.

Every parameter has two stages. The buffer stage is what software writes and what software reads back. The active stage is what the generator compares against. The active stage stays unchanged until the high byte of the commit register (index 2) is written. That write arms a pending flag. At the next period-end pulse, all five buffered values move into the active stage in the same cycle and the flag drops. Because a read returns the buffered value, it can differ from the waveform currently being produced.

Top module: `pwm_param_bank`

## Requirements
- R1: After synchronous reset, every buffered value, every active value, `commit_pending` and `bus_rdata` are zero.
- R2: A write to a low-byte address (even address, register index = address/2) changes no buffered value and no readback. It only loads the holding latch of that register.
- R3: A write to a high-byte address (odd address) sets that register's buffered value to {wdata[1:0], last low byte written to that register}. A read of the even address returns buffered bits [7:0].
- R4: Write data bits [7:2] at a high-byte address are discarded. A read of a high-byte address returns {6'b0, buffered bits [9:8]}.
- R5: The active values change only at a period-end pulse while the commit flag is set. Buffer writes to registers 0, 1, 3 and 4 never set the flag.
- R6: A write to the high byte of register 2 (address 5) sets `commit_pending` at the clock edge that takes the write.
- R7: When `period_end` is high at a clock edge while `commit_pending` is set, all five buffered values are copied to `active_flat` at that edge. Register i occupies bits [10i+9:10i]. The flag clears at the same edge.
- R8: A period-end pulse while `commit_pending` is clear leaves all active values unchanged.
- R9: A read returns the buffered value, even when it differs from the active value.
- R10: Addresses 10 to 15 are unmapped. Writes to them change no buffered value, active value or flag, and reads of them return 0.
- R11: `bus_rdata` is registered. It shows the addressed byte in the cycle after a cycle with `bus_re` high, and it is 0 after a cycle with `bus_re` low.
- R12: If a commit write and a period-end pulse arrive in the same cycle while the flag is already set, the active stage takes the buffer contents from before that write, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address; register i at 2i (low) and 2i+1 (high) |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| period_end | input | 1 | One-cycle pulse at the end of each generator period |
| commit_pending | output | 1 | Set by a commit write, cleared by the transfer |
| active_flat | output | 50 | Active values of all five registers, register i at [10i+9:10i] |

## Verification
A write takes effect at the edge that samples the strobe. A read issued in the next cycle returns its data one edge later, so the bench drives on falling edges and samples `bus_rdata` at the falling edge that follows the read edge. `commit_pending` and `active_flat` change at the same edge that samples the commit write or the period-end pulse. The bench checks them at the falling edge right after that edge, against a model that applies any transfer before it applies the write in the same cycle. An exhaustive sweep of all 1024 values through every register, with junk in the discarded high bits, covers the byte assembly and the readback path.

// File: rtl/pwm_param_pkg.sv
// Shared definitions for the pulse parameter register bank.
// Assumes a byte-wide bus and the low byte at the even address.
package pwm_param_pkg;

    localparam int BUS_W = 8;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Which byte of a register an address selects.
    function automatic lane_e addr_lane(input logic addr_lsb);
        return addr_lsb ? LANE_HI : LANE_LO;
    endfunction

endpackage

// File: rtl/ppb_addr_decode.sv
// Address decoder: turns a byte address into one-hot low/high lane selects.
// Assumes register i occupies addresses 2i and 2i+1; anything else selects nothing.
module ppb_addr_decode
    import pwm_param_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int ADDR_W   = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel_lo,
    output logic [NUM_REGS-1:0] sel_hi
);

    lane_e lane;

    // Pick the byte lane from the address LSB.
    always_comb lane = addr_lane(addr[0]);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        logic hit;
        // Compare the word part of the address against this register index.
        always_comb begin
            hit       = (addr[ADDR_W-1:1] == (ADDR_W-1)'(i));
            sel_lo[i] = hit && (lane == LANE_LO);
            sel_hi[i] = hit && (lane == LANE_HI);
        end
    end

endmodule

// File: rtl/ppb_param_reg.sv
// One buffered parameter: a low-byte holding latch plus the buffer word.
// Assumes the low byte is written before the high byte; the buffer only
// changes on the high-byte write, so a half value is never exposed.
module ppb_param_reg
    import pwm_param_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BUS_W-1:0]  wr_byte,
    output logic [DATA_W-1:0] buf_q
);

    localparam int HI_W = DATA_W - BUS_W;

    logic [BUS_W-1:0] lo_hold;
    logic [HI_W-1:0]  hi_part;

    // Only the meaningful high bits of the byte reach the buffer.
    always_comb hi_part = wr_byte[HI_W-1:0];

    // Keep the low byte until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_hold <= '0;
        else if (lo_we) lo_hold <= wr_byte;
    end

    // Assemble the full word on the high-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)     buf_q <= '0;
        else if (hi_we) buf_q <= {hi_part, lo_hold};
    end

endmodule

// File: rtl/ppb_commit_ctrl.sv
// Commit sequencing: a commit write arms a pending flag; the next period-end
// pulse with the flag set issues a single load strobe and drops the flag.
// Assumes a commit write in the same cycle as a transfer re-arms the flag.
module ppb_commit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_we,
    input  logic period_end,
    output logic pending,
    output logic load
);

    // A transfer happens only at a period boundary while armed.
    always_comb load = period_end && pending;

    // Arm on a commit write, disarm after the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending <= 1'b0;
        else if (commit_we)  pending <= 1'b1;
        else if (period_end) pending <= 1'b0;
    end

endmodule

// File: rtl/pwm_param_bank.sv
// Double-buffered parameter bank for a pulse generator. Bytes from the CPU
// build buffered words; a commit write plus a period-end pulse moves every
// buffered word into the active stage at once. Reads return buffered words.
// Assumes one bus access per cycle and a one-cycle period_end pulse.
module pwm_param_bank
    import pwm_param_pkg::*;
#(
    parameter int NUM_REGS   = 5,
    parameter int DATA_W     = 10,
    parameter int ADDR_W     = 4,
    parameter int COMMIT_IDX = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BUS_W-1:0]           bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic                       period_end,
    output logic                       commit_pending,
    output logic [NUM_REGS*DATA_W-1:0] active_flat
);

    localparam int HI_W = DATA_W - BUS_W;

    logic [NUM_REGS-1:0]        sel_lo, sel_hi;
    logic [NUM_REGS-1:0]        wr_lo, wr_hi;
    logic [NUM_REGS*DATA_W-1:0] buf_flat;
    logic                       commit_we;
    logic                       load;
    logic [BUS_W-1:0]           rd_word;

    ppb_addr_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .addr   (bus_addr),
        .sel_lo (sel_lo),
        .sel_hi (sel_hi)
    );

    // Qualify the address selects with the write strobe.
    always_comb begin
        wr_lo     = sel_lo & {NUM_REGS{bus_we}};
        wr_hi     = sel_hi & {NUM_REGS{bus_we}};
        commit_we = wr_hi[COMMIT_IDX];
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        ppb_param_reg #(
            .DATA_W (DATA_W)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .lo_we   (wr_lo[i]),
            .hi_we   (wr_hi[i]),
            .wr_byte (bus_wdata),
            .buf_q   (buf_flat[i*DATA_W +: DATA_W])
        );

        // Active stage: take the buffered word on a transfer strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)    active_flat[i*DATA_W +: DATA_W] <= '0;
            else if (load) active_flat[i*DATA_W +: DATA_W] <= buf_flat[i*DATA_W +: DATA_W];
        end
    end

    ppb_commit_ctrl u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_we  (commit_we),
        .period_end (period_end),
        .pending    (commit_pending),
        .load       (load)
    );

    // Select the addressed byte of the buffer stage; unused high bits are zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel_lo[i]) rd_word = rd_word | buf_flat[i*DATA_W +: BUS_W];
            if (sel_hi[i]) rd_word = rd_word |
                {{(BUS_W-HI_W){1'b0}}, buf_flat[i*DATA_W+BUS_W +: HI_W]};
        end
    end

    // Register the read data; zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/pwm_param_bank_chk.sv
// Property checker for the parameter bank, attached to every instance of the
// top module by the bind below. Observes ports and the buffered words.
module pwm_param_bank_chk #(
    parameter int NUM_REGS   = 5,
    parameter int DATA_W     = 10,
    parameter int ADDR_W     = 4,
    parameter int COMMIT_IDX = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_we,
    input logic                       bus_re,
    input logic [7:0]                 bus_rdata,
    input logic                       period_end,
    input logic                       commit_pending,
    input logic [NUM_REGS*DATA_W-1:0] active_flat,
    input logic [NUM_REGS*DATA_W-1:0] buf_flat
);

    localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(2*COMMIT_IDX + 1);
    localparam logic [ADDR_W-1:0] FIRST_FREE  = ADDR_W'(2*NUM_REGS);

    logic commit_seen;
    logic transfer;
    logic hi_read;
    logic free_read;

    // Events derived from the port activity.
    always_comb begin
        commit_seen = bus_we && (bus_addr == COMMIT_ADDR);
        transfer    = period_end && commit_pending;
        hi_read     = bus_re && bus_addr[0] && (bus_addr < FIRST_FREE);
        free_read   = bus_re && (bus_addr >= FIRST_FREE);
    end

    // Active words hold unless a transfer is due.
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !transfer |=> $stable(active_flat));

    // A commit write arms the flag.
    assert_commit_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_seen |=> commit_pending);

    // A transfer copies the buffered words that existed before it.
    assert_transfer_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        transfer |=> (active_flat == $past(buf_flat)));

    // A transfer without a new commit disarms the flag.
    assert_transfer_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (transfer && !commit_seen) |=> !commit_pending);

    // The flag never rises without a commit write.
    assert_no_spurious_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_seen && !commit_pending) |=> !commit_pending);

    // High-byte reads carry zeros above the valid bits.
    assert_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_read |=> (bus_rdata[7:2] == 6'd0));

    // Unmapped reads return zero.
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        free_read |=> (bus_rdata == 8'd0));

    // Idle read port returns zero.
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == 8'd0));

endmodule

bind pwm_param_bank pwm_param_bank_chk #(
    .NUM_REGS   (NUM_REGS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .COMMIT_IDX (COMMIT_IDX)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_rdata      (bus_rdata),
    .period_end     (period_end),
    .commit_pending (commit_pending),
    .active_flat    (active_flat),
    .buf_flat       (buf_flat)
);

// File: tb/pwm_param_bank_tb.sv
// Self-checking bench: drives on falling edges, samples on falling edges,
// and compares against an arithmetic model of the buffer and active stages.
module pwm_param_bank_tb;

    localparam int N = 5;
    localparam int W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        period_end = 1'b0;
    logic        commit_pending;
    logic [N*W-1:0] active_flat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int exp_buf[N];
    int exp_lo[N];
    int exp_act[N];
    bit exp_pend;

    always #2 clk = ~clk;

    pwm_param_bank u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_we         (bus_we),
        .bus_re         (bus_re),
        .bus_rdata      (bus_rdata),
        .period_end     (period_end),
        .commit_pending (commit_pending),
        .active_flat    (active_flat)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        for (int i = 0; i < N; i++) chk(req, int'(active_flat[i*W +: W]), exp_act[i]);
        chk(req, int'(commit_pending), int'(exp_pend));
    endtask

    function automatic int exp_rd(input int a);
        if (a >= 2*N) return 0;
        if (a % 2 == 0) return exp_buf[a/2] & 255;
        return exp_buf[a/2] >> 8;
    endfunction

    // One write cycle, optionally with a period-end pulse in the same cycle.
    task automatic bus_wr(input int a, input int d, input bit with_pe);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_we = 1'b1; period_end = with_pe;
        @(negedge clk);
        bus_we = 1'b0; period_end = 1'b0;
        if (with_pe && exp_pend) begin
            for (int i = 0; i < N; i++) exp_act[i] = exp_buf[i];
            exp_pend = 1'b0;
        end
        if (a < 2*N) begin
            if (a % 2 == 0) exp_lo[a/2] = d & 255;
            else begin
                exp_buf[a/2] = ((d & 3) << 8) | exp_lo[a/2];
                if (a/2 == 2) exp_pend = 1'b1;
            end
        end
    endtask

    task automatic pulse_pe();
        @(negedge clk);
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
        if (exp_pend) begin
            for (int i = 0; i < N; i++) exp_act[i] = exp_buf[i];
            exp_pend = 1'b0;
        end
    endtask

    task automatic rd_chk(input string req, input int a);
        @(negedge clk);
        bus_addr = 4'(a); bus_re = 1'b1;
        @(negedge clk);
        chk(req, int'(bus_rdata), exp_rd(a));
        bus_re = 1'b0;
    endtask

    task automatic wr_word(input int idx, input int v);
        bus_wr(2*idx, v & 255, 1'b0);
        bus_wr(2*idx + 1, (v >> 8) | (((v * 37) & 63) << 2), 1'b0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            exp_buf[i] = 0; exp_lo[i] = 0; exp_act[i] = 0;
        end
        exp_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1 rdata", int'(bus_rdata), 0);
        chk_state("R1 state");
        for (int a = 0; a < 2*N; a++) rd_chk("R1 readback", a);

        // R2: a low byte alone is invisible
        bus_wr(0, 8'h5A, 1'b0);
        rd_chk("R2 lo unchanged", 0);
        rd_chk("R2 hi unchanged", 1);
        bus_wr(1, 8'hFE, 1'b0);
        rd_chk("R3 lo completes", 0);
        rd_chk("R4 hi masked", 1);

        // R5/R8/R9: non-commit registers do not arm; reads show buffer
        wr_word(1, 10'h2C3);
        wr_word(3, 10'h155);
        wr_word(4, 10'h3FF);
        chk_state("R5 no arm");
        pulse_pe();
        chk_state("R8 idle period end");
        rd_chk("R9 buffer read lo", 6);
        rd_chk("R9 buffer read hi", 7);
        chk("R9 active differs", int'(active_flat[3*W +: W]), 0);

        // R6/R7: commit and transfer
        wr_word(2, 10'h1A7);
        chk_state("R6 armed");
        pulse_pe();
        chk_state("R7 transfer");
        pulse_pe();
        chk_state("R8 after transfer");

        // R12: commit write colliding with a transfer
        wr_word(0, 10'h0F1);
        wr_word(2, 10'h222);
        bus_wr(4, 8'h33, 1'b0);
        bus_wr(5, 8'h01, 1'b1);
        chk_state("R12 collision");
        pulse_pe();
        chk_state("R12 follow-up");

        // R10: unmapped addresses
        for (int a = 2*N; a < 16; a++) bus_wr(a, 8'hFF, 1'b0);
        chk_state("R10 no effect");
        for (int a = 0; a < 16; a++) rd_chk("R10 readback", a);

        // R11: read port idles at zero
        rd_chk("R11 read", 6);
        @(negedge clk);
        chk("R11 idle zero", int'(bus_rdata), 0);

        // R3/R4: exhaustive value sweep on every register
        for (int i = 0; i < N; i++) begin
            for (int v = 0; v < 1024; v++) begin
                wr_word(i, v);
                rd_chk("R3 sweep lo", 2*i);
                rd_chk("R4 sweep hi", 2*i + 1);
            end
        end
        chk_state("R5 after sweep");
        pulse_pe();
        chk_state("R7 after sweep");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule